// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block keeps a free-running 32-bit time base and watches one selectable bit of it. Each rising transition of the watched bit is a timeout event. Timeouts climb a ladder of three steps. The first timeout only arms the watchdog as an early warning. The next one marks an interrupt as pending. A timeout that arrives while that interrupt is still pending sends a hardware reset request to an external reset controller. Software moves the watchdog back down the ladder by writing a clear mask to the status register before the next timeout arrives.

Software writes go through a single write port. A two-bit target code selects one of three destinations: the control register (period select, interrupt enable and reset kind), the status clear mask, or a direct load of the time base. Once the reset kind field holds a non-zero value, no software write can lower it. Only a hardware reset returns it to zero. A timeout and a status clear in the same cycle resolve in favour of the timeout.

Top module: `wdt_escalation`

## Requirements
- R1: After reset, the time base is 0, both status flags are 0, the control fields are 0, and irq and rst_req are 0.
- R2: The time base increments by exactly one on each clock in which tick_en is 1 and holds otherwise. A write with wr_target = 2 loads wr_data into it instead of incrementing.
- R3: The control period select (wr_data[1:0] of a write with wr_target = 0) picks the watched time base bit 16 + 4*sel, counting bit 0 as the least significant. This gives timeout periods of 2^17, 2^21, 2^25 and 2^29 ticks for sel = 0..3.
- R4: A timeout while stat_arm = 0 sets stat_arm on the following clock edge. It leaves stat_pend, irq and rst_req at 0.
- R5: A timeout while stat_arm = 1 and stat_pend = 0 sets stat_pend on the following edge. irq is 1 exactly while stat_pend, ctl_ie (control wr_data[2]) and crit_en are all 1.
- R6: A timeout while stat_arm = 1 and stat_pend = 1 raises rst_req for exactly one cycle on the following edge, with rst_kind equal to ctl_rc, when ctl_rc is non-zero. When ctl_rc is 0 it produces no pulse. rst_kind is 0 whenever rst_req is 0.
- R7: A write with wr_target = 1 is a clear mask. wr_data[0] = 1 clears stat_arm, wr_data[1] = 1 clears stat_pend, and a 0 bit leaves its flag unchanged.
- R8: ctl_rc (control wr_data[5:4]) takes the written value only while it is 0. Once it is non-zero, control writes leave it unchanged until reset.
- R9: A time base load, or a change of period select, produces no timeout even when the watched bit goes from 0 to 1 as a result.
- R10: When a timeout and a status clear of the same flag fall in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time base increment enable |
| wr_en | input | 1 | Software write strobe |
| wr_target | input | 2 | Write destination: 0 control, 1 status clear mask, 2 time base, 3 none |
| wr_data | input | 32 | Write data |
| crit_en | input | 1 | External critical-interrupt enable |
| irq | output | 1 | Watchdog interrupt, level |
| rst_req | output | 1 | One-cycle reset request pulse |
| rst_kind | output | 2 | Reset kind carried with rst_req |
| tb_count | output | 32 | Current time base value |
| stat_arm | output | 1 | Status: first timeout seen |
| stat_pend | output | 1 | Status: interrupt pending |
| ctl_sel | output | 2 | Control: period select |
| ctl_ie | output | 1 | Control: interrupt enable |
| ctl_rc | output | 2 | Control: sticky reset kind |

## Verification
A tick or time base load changes tb_count at the next edge. The timeout it may cause is seen combinationally in the cycle after that, so the status flags and rst_req move one further edge later, two edges after the tick. irq follows the flags and crit_en with no extra register, and control and status writes show on the outputs one edge after the write. The bench drives every input just after a falling edge and samples on the next falling edge after the required number of rising edges, so each check lands in the exact cycle the result is due. It also checks the cycle before or after for the pulse and for the ignored cases.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WT_CTRL  = 2'd0,
    WT_STAT  = 2'd1,
    WT_TBASE = 2'd2,
    WT_NONE  = 2'd3
  } wr_target_e;

  // control write field positions
  localparam int CF_SEL_LO = 0;
  localparam int CF_IE     = 2;
  localparam int CF_RC_LO  = 4;

  // status clear mask positions
  localparam int SF_ARM  = 0;
  localparam int SF_PEND = 1;

  // little-endian index of the watched time base bit
  function automatic int watched_bit(input int sel, input int base, input int step);
    return base + step * sel;
  endfunction

endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         loaded_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= load_en;
      if (load_en)      count <= load_val;
      else if (tick_en) count <= count + W'(1);
    end
  end

  AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load_en) |=> (count == $past(count) + W'(1))); // R2
  AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_en) |=> $stable(count)); // R2

endmodule

// File: rtl/wdt_edge.sv
module wdt_edge #(
  parameter int W     = 32,
  parameter int SEL_W = 2,
  parameter int BASE  = 16,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     count,
  input  logic [SEL_W-1:0] sel,
  input  logic             loaded_q,
  output logic             tmo
);
  import wdt_pkg::*;

  localparam int IDX_W = $clog2(W);

  logic [IDX_W-1:0] idx;
  logic             cur_bit;
  logic             seen_q;
  logic [SEL_W-1:0] sel_q;
  logic             sel_moved;

  always_comb begin
    idx       = IDX_W'(watched_bit(int'(sel), BASE, STEP));
    cur_bit   = count[idx];
    sel_moved = (sel != sel_q);
    tmo       = cur_bit && !seen_q && !sel_moved && !loaded_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      seen_q <= cur_bit;
      sel_q  <= sel;
    end
  end

  AST_NO_SEL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> !tmo); // R9
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo); // R3

endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs #(
  parameter int W     = 32,
  parameter int SEL_W = 2,
  parameter int RC_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [W-1:0]     wr_data,
  output logic [SEL_W-1:0] sel,
  output logic             ie,
  output logic [RC_W-1:0]  rc
);
  import wdt_pkg::*;

  logic [SEL_W-1:0] sel_field;
  logic [RC_W-1:0]  rc_field;
  logic             rc_locked;

  always_comb begin
    sel_field = wr_data[CF_SEL_LO +: SEL_W];
    rc_field  = wr_data[CF_RC_LO +: RC_W];
    rc_locked = (rc != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
      ie  <= 1'b0;
      rc  <= '0;
    end else if (wr_ctrl) begin
      sel <= sel_field;
      ie  <= wr_data[CF_IE];
      if (!rc_locked) rc <= rc_field;
    end
  end

  AST_RC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rc != '0) |=> $stable(rc)); // R8

endmodule

// File: rtl/wdt_status.sv
module wdt_status #(
  parameter int RC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tmo,
  input  logic            wr_stat,
  input  logic [1:0]      clr_mask,
  input  logic [RC_W-1:0] rc,
  input  logic            ie,
  input  logic            crit_en,
  output logic            arm,
  output logic            pend,
  output logic            irq,
  output logic            rst_req,
  output logic [RC_W-1:0] rst_kind
);
  import wdt_pkg::*;

  logic set_arm, set_pend, escalate;
  logic clr_arm, clr_pend;
  logic fire_rst;

  always_comb begin
    set_arm  = tmo && !arm;
    set_pend = tmo && arm && !pend;
    escalate = tmo && arm && pend;
    clr_arm  = wr_stat && clr_mask[SF_ARM];
    clr_pend = wr_stat && clr_mask[SF_PEND];
    fire_rst = escalate && (rc != '0);
    irq      = pend && ie && crit_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm      <= 1'b0;
      pend     <= 1'b0;
      rst_req  <= 1'b0;
      rst_kind <= '0;
    end else begin
      arm      <= set_arm  || (arm  && !clr_arm);
      pend     <= set_pend || (pend && !clr_pend);
      rst_req  <= fire_rst;
      rst_kind <= fire_rst ? rc : '0;
    end
  end

  AST_ARM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !arm) |=> (arm && !rst_req)); // R4
  AST_PEND_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && arm && !pend) |=> pend); // R5
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend && crit_en)); // R5
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6
  AST_RST_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_kind != '0)); // R6
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(arm) && $past(pend))); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !arm && wr_stat) |=> arm); // R10

endmodule

// File: rtl/wdt_escalation.sv
module wdt_escalation #(
  parameter int TB_W  = 32,
  parameter int SEL_W = 2,
  parameter int RC_W  = 2,
  parameter int BASE  = 16,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_target,
  input  logic [TB_W-1:0]  wr_data,
  input  logic             crit_en,
  output logic             irq,
  output logic             rst_req,
  output logic [RC_W-1:0]  rst_kind,
  output logic [TB_W-1:0]  tb_count,
  output logic             stat_arm,
  output logic             stat_pend,
  output logic [SEL_W-1:0] ctl_sel,
  output logic             ctl_ie,
  output logic [RC_W-1:0]  ctl_rc
);
  import wdt_pkg::*;

  logic wr_ctrl, wr_stat, wr_tb;
  logic tb_loaded_q;
  logic tmo;

  always_comb begin
    wr_ctrl = wr_en && (wr_target == WT_CTRL);
    wr_stat = wr_en && (wr_target == WT_STAT);
    wr_tb   = wr_en && (wr_target == WT_TBASE);
  end

  wdt_timebase #(.W(TB_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .load_en(wr_tb), .load_val(wr_data),
    .count(tb_count), .loaded_q(tb_loaded_q)
  );

  wdt_edge #(.W(TB_W), .SEL_W(SEL_W), .BASE(BASE), .STEP(STEP)) u_edge (
    .clk(clk), .rst_n(rst_n), .count(tb_count), .sel(ctl_sel),
    .loaded_q(tb_loaded_q), .tmo(tmo)
  );

  wdt_ctrl_regs #(.W(TB_W), .SEL_W(SEL_W), .RC_W(RC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .sel(ctl_sel), .ie(ctl_ie), .rc(ctl_rc)
  );

  wdt_status #(.RC_W(RC_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .tmo(tmo), .wr_stat(wr_stat),
    .clr_mask(wr_data[1:0]), .rc(ctl_rc), .ie(ctl_ie), .crit_en(crit_en),
    .arm(stat_arm), .pend(stat_pend), .irq(irq),
    .rst_req(rst_req), .rst_kind(rst_kind)
  );

  AST_LOAD_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tb |=> !tmo); // R9
  AST_ESCALATE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && stat_arm && stat_pend && ctl_rc != '0) |=> rst_req); // R6

endmodule

// File: tb/wdt_escalation_bench.sv
module wdt_escalation_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_target = 2'd3;
  logic [31:0] wr_data = '0;
  logic        crit_en = 1'b0;
  logic        irq, rst_req, stat_arm, stat_pend, ctl_ie;
  logic [1:0]  rst_kind, ctl_sel, ctl_rc;
  logic [31:0] tb_count;

  int checks = 0;
  int errors = 0;

  // period select vs period exponent, restated from the requirement
  localparam int VSEL [4] = '{0, 1, 2, 3};
  localparam int VEXP [4] = '{17, 21, 25, 29};

  always #10 clk = ~clk;

  wdt_escalation u_wdt_escalation (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_target(wr_target), .wr_data(wr_data), .crit_en(crit_en),
    .irq(irq), .rst_req(rst_req), .rst_kind(rst_kind), .tb_count(tb_count),
    .stat_arm(stat_arm), .stat_pend(stat_pend), .ctl_sel(ctl_sel),
    .ctl_ie(ctl_ie), .ctl_rc(ctl_rc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] tgt, input logic [31:0] d);
    wr_en = 1'b1; wr_target = tgt; wr_data = d;
    step();
    wr_en = 1'b0; wr_target = 2'd3; wr_data = '0;
  endtask

  task automatic tick();
    tick_en = 1'b1;
    step();
    tick_en = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(input int sel, input int ie, input int rc);
    return 32'((rc << 4) | (ie << 2) | sel);
  endfunction

  // load just below the watched bit, tick across it, let status update
  task automatic fire(input int bitpos);
    wr(2'd2, (32'd1 << bitpos) - 32'd1);
    tick();
    step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 tb", tb_count, 32'd0);
    check("R1 arm", {31'd0, stat_arm}, 32'd0);
    check("R1 pend", {31'd0, stat_pend}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rst_req", {31'd0, rst_req}, 32'd0);
    check("R1 rc", {30'd0, ctl_rc}, 32'd0);

    // R2 counting and hold
    tick(); tick(); tick();
    check("R2 three ticks", tb_count, 32'd3);
    step(); step();
    check("R2 hold", tb_count, 32'd3);
    wr(2'd2, 32'hFFFF_FFFF);
    check("R2 load", tb_count, 32'hFFFF_FFFF);
    tick();
    check("R2 wrap", tb_count, 32'd0);

    // R3/R4 table: each select watches its own bit
    for (int i = 0; i < 4; i++) begin
      int b;
      b = VEXP[i] - 1;
      wr(2'd0, ctrl_word(VSEL[i], 0, 0));
      wr(2'd1, 32'd3);
      wr(2'd2, (32'd1 << b) - 32'd2);
      tick(); step();
      check("R3 below bit no event", {31'd0, stat_arm}, 32'd0);
      tick(); step();
      check("R3 watched bit arms", {31'd0, stat_arm}, 32'd1);
      check("R4 no pend", {31'd0, stat_pend}, 32'd0);
      check("R4 no reset", {31'd0, rst_req}, 32'd0);
      // other select's bit must not arm
      wr(2'd1, 32'd3);
      wr(2'd2, (32'd1 << ((b == 16) ? 20 : 16)) - 32'd1);
      tick(); step();
      check("R3 other bit ignored", {31'd0, stat_arm}, 32'd0);
    end

    // R5 pending and irq level
    wr(2'd0, ctrl_word(0, 1, 0));
    wr(2'd1, 32'd3);
    fire(16);
    check("R4 first arms", {31'd0, stat_arm}, 32'd1);
    check("R4 irq quiet", {31'd0, irq}, 32'd0);
    fire(16);
    check("R5 pend set", {31'd0, stat_pend}, 32'd1);
    check("R5 irq needs crit", {31'd0, irq}, 32'd0);
    crit_en = 1'b1; #1;
    check("R5 irq level", {31'd0, irq}, 32'd1);
    step(); step();
    check("R5 irq holds", {31'd0, irq}, 32'd1);
    wr(2'd0, ctrl_word(0, 0, 0));
    check("R5 irq off with ie 0", {31'd0, irq}, 32'd0);

    // R7 clear mask
    wr(2'd1, 32'd1);
    check("R7 arm cleared", {31'd0, stat_arm}, 32'd0);
    check("R7 pend kept", {31'd0, stat_pend}, 32'd1);
    wr(2'd1, 32'd0);
    check("R7 zero mask no effect", {30'd0, stat_arm, stat_pend}, 32'd1);
    wr(2'd1, 32'd2);
    check("R7 pend cleared", {31'd0, stat_pend}, 32'd0);

    // R6 escalation with rc = 0: no pulse
    fire(16); fire(16);
    check("R6 both set", {30'd0, stat_arm, stat_pend}, 32'd3);
    fire(16);
    check("R6 rc0 no pulse", {31'd0, rst_req}, 32'd0);
    check("R6 rc0 kind", {30'd0, rst_kind}, 32'd0);
    // rc = 2: one-cycle pulse with kind
    wr(2'd0, ctrl_word(0, 0, 2));
    fire(16);
    check("R6 pulse", {31'd0, rst_req}, 32'd1);
    check("R6 kind", {30'd0, rst_kind}, 32'd2);
    step();
    check("R6 pulse one cycle", {31'd0, rst_req}, 32'd0);
    check("R6 kind idle", {30'd0, rst_kind}, 32'd0);

    // R8 sticky reset kind
    wr(2'd0, ctrl_word(0, 0, 0));
    check("R8 rc not cleared", {30'd0, ctl_rc}, 32'd2);
    wr(2'd0, ctrl_word(1, 1, 1));
    check("R8 rc not rewritten", {30'd0, ctl_rc}, 32'd2);
    check("R8 other fields written", {29'd0, ctl_ie, ctl_sel}, 32'd5);
    do_reset();
    check("R8 rc zero after reset", {30'd0, ctl_rc}, 32'd0);

    // R9 load sets watched bit: no event
    wr(2'd2, 32'h0001_0000);
    step();
    check("R9 load no event", {31'd0, stat_arm}, 32'd0);
    // select change onto a set bit: no event
    wr(2'd2, 32'h0010_0000);
    step();
    wr(2'd0, ctrl_word(1, 0, 0));
    step(); step();
    check("R9 select change no event", {31'd0, stat_arm}, 32'd0);

    // R10 timeout and clear together
    wr(2'd0, ctrl_word(0, 0, 0));
    wr(2'd2, 32'h0000_FFFF);
    tick();
    wr(2'd1, 32'd3);
    check("R10 arm set wins", {31'd0, stat_arm}, 32'd1);
    wr(2'd2, 32'h0000_FFFF);
    tick();
    wr(2'd1, 32'd2);
    check("R10 pend set wins", {31'd0, stat_pend}, 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule